// File: doc/BRIEF.md
# Rolling-Window Activate Limiter

This block guards each rank of a DRAM channel against more than four row activations inside a sliding window of controller clock cycles. The command scheduler raises a one-cycle strobe for every activate or refresh it sends to a rank. The limiter records each strobe in a per-rank history and returns a per-rank permission bit that the scheduler must consult before issuing the next activate or refresh to that rank.

Each rank keeps a shift register as long as the window, plus a running count of the ones it holds. A strobe sets the top bit. Every cycle the oldest bit falls off the bottom end and is subtracted from the count. Permission depends on the count after this cycle's retirement, so a slot freed in a cycle can be reused in that same cycle. A window length of zero builds no history at all, and the limiter then never blocks.

Top module: `act_window_limiter`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, every bit of `act_ok_o` is 1.
- R2: A record made in cycle t counts against its rank in cycles t+1 through t+WIN_LEN-1 and no longer from cycle t+WIN_LEN on; permission never falls unless that rank recorded something in the cycle before.
- R3: `act_ok_o[r]` is 0 exactly when rank r holds 4 or more counted records, and 1 otherwise.
- R4: A refresh strobe on `ref_i[r]` is recorded exactly like an activate strobe on `act_i[r]`.
- R5: An activate and a refresh to the same rank in the same cycle make one record, not two.
- R6: Retirement of the oldest record happens before the current cycle's new record is added, so a record in the cycle a slot frees leaves a correct count.
- R7: Ranks are independent: strobes to one rank never change the permission of another.
- R8: With WIN_LEN = 0 nothing is recorded and every bit of `act_ok_o` stays 1 whatever the strobes.
- R9: A strobe to a rank whose permission bit is 0 is a protocol violation flagged by an assertion; WIN_LEN must lie in 0..62.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| act_i | input | NUM_RANKS | One-cycle activate strobe per rank |
| ref_i | input | NUM_RANKS | One-cycle refresh strobe per rank |
| act_ok_o | output | NUM_RANKS | Per-rank permission for a further activate or refresh this cycle |

## Verification
Two events can meet in one cycle on a rank: the oldest record reaching the bottom of the shift register and a new strobe being recorded. A separate collision is an activate and a refresh landing together. The bench provokes the first by strobing one rank in every cycle its permission allows, so each reopened slot is refilled in the very cycle it frees. It provokes the second by raising both strobes together on another rank. A scoreboard model that keeps only the cycle numbers of past records judges every cycle's permission vector. It counts the records whose age lies within the window, treats a coincident pair as one record, and would catch a retirement applied after the new record or a pair counted twice.

// File: rtl/awl_pkg.sv
package awl_pkg;
  localparam int unsigned ACT_LIMIT = 4;
  localparam int unsigned WIN_MAX   = 62;

  function automatic int unsigned cnt_width(int unsigned win_len);
    int unsigned top;
    top = (win_len > ACT_LIMIT) ? win_len : ACT_LIMIT;
    return $clog2(top + 1);
  endfunction
endpackage

// File: rtl/awl_rank_window.sv
module awl_rank_window #(
  parameter int unsigned WIN_LEN = 16,
  parameter int unsigned CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rec_i,
  output logic [CW-1:0] eff_cnt_o,
  output logic [CW-1:0] cnt_q_o
);
  logic [WIN_LEN-1:0] shift_q, shift_d;
  logic [CW-1:0]      cnt_q, cnt_d, eff_cnt;
  logic               upd_en;

  always_comb begin
    eff_cnt = cnt_q - CW'(shift_q[0]);
    shift_d = shift_q >> 1;
    cnt_d   = eff_cnt;
    if (rec_i) begin
      shift_d[WIN_LEN-1] = 1'b1;
      cnt_d              = eff_cnt + CW'(1);
    end
    upd_en = rec_i | (|shift_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  assign eff_cnt_o = eff_cnt;
  assign cnt_q_o   = cnt_q;
endmodule

// File: rtl/awl_gate.sv
module awl_gate #(
  parameter int unsigned CW = 5
) (
  input  logic [CW-1:0] eff_cnt_i,
  output logic          ok_o
);
  import awl_pkg::*;
  assign ok_o = (32'(eff_cnt_i) < ACT_LIMIT);
endmodule

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned WIN_LEN   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RANKS-1:0] act_i,
  input  logic [NUM_RANKS-1:0] ref_i,
  output logic [NUM_RANKS-1:0] act_ok_o
);
  import awl_pkg::*;
  localparam int unsigned CW = cnt_width(WIN_LEN);

  logic [NUM_RANKS-1:0]         rec;
  logic [NUM_RANKS-1:0][CW-1:0] win_cnt;

  assign rec = act_i | ref_i;

  generate
    if (WIN_LEN == 0) begin : g_off
      assign act_ok_o = '1;
      assign win_cnt  = '0;
    end else begin : g_on
      for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic [CW-1:0] eff;
        awl_rank_window #(.WIN_LEN(WIN_LEN), .CW(CW)) win_i (
          .clk      (clk),
          .rst_n    (rst_n),
          .rec_i    (rec[r]),
          .eff_cnt_o(eff),
          .cnt_q_o  (win_cnt[r])
        );
        awl_gate #(.CW(CW)) gate_i (
          .eff_cnt_i(eff),
          .ok_o     (act_ok_o[r])
        );
      end
    end
  endgenerate
endmodule

// File: rtl/act_window_limiter_chk.sv
module act_window_limiter_chk #(
  parameter int unsigned NUM_RANKS = 4,
  parameter int unsigned CW        = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_RANKS-1:0]         act_i,
  input logic [NUM_RANKS-1:0]         ref_i,
  input logic [NUM_RANKS-1:0]         act_ok_o,
  input logic [NUM_RANKS-1:0][CW-1:0] cnt_i
);
  import awl_pkg::*;
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    assert_no_blocked_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act_i[r] | ref_i[r]) |-> act_ok_o[r]);
    assert_stay_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(act_ok_o[r]) && !$past(act_i[r] | ref_i[r])) |-> act_ok_o[r]);
    assert_fall_needs_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_ok_o[r]) |-> $past(act_i[r] | ref_i[r]));
    assert_count_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt_i[r]) <= ACT_LIMIT);
  end
endmodule

bind act_window_limiter act_window_limiter_chk #(.NUM_RANKS(NUM_RANKS), .CW(CW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .act_i   (act_i),
  .ref_i   (ref_i),
  .act_ok_o(act_ok_o),
  .cnt_i   (win_cnt)
);

// File: tb/act_window_limiter_tb_top.sv
module act_window_limiter_tb_top;
  localparam int NR = 4;
  localparam int W  = 10;

  logic clk, rst_n;
  logic [NR-1:0] act_i, ref_i, act_ok, off_ok;

  act_window_limiter #(.NUM_RANKS(NR), .WIN_LEN(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .ref_i(ref_i), .act_ok_o(act_ok));
  act_window_limiter #(.NUM_RANKS(NR), .WIN_LEN(0)) dut_off_i (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .ref_i(ref_i), .act_ok_o(off_ok));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { logic [NR-1:0] exp; string tag; } exp_t;
  exp_t sb_q[$];
  exp_t cur;
  int hist[NR][$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [NR-1:0] model_ok();
    logic [NR-1:0] v;
    for (int r = 0; r < NR; r++) begin
      int n = 0;
      foreach (hist[r][i]) begin
        if ((cyc - hist[r][i] >= 1) && (cyc - hist[r][i] <= W - 1)) n++;
      end
      v[r] = (n < 4);
    end
    return v;
  endfunction

  task automatic step(input logic [NR-1:0] a, input logic [NR-1:0] f, input string tag);
    exp_t e;
    logic [NR-1:0] am, fm;
    @(negedge clk);
    e.exp = model_ok();
    e.tag = tag;
    sb_q.push_back(e);
    am = a & e.exp;
    fm = f & e.exp;
    act_i = am;
    ref_i = fm;
    for (int r = 0; r < NR; r++) if (am[r] | fm[r]) hist[r].push_back(cyc);
    cyc++;
  endtask

  // monitor: pops expectations and compares away from the clock edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        cur = sb_q.pop_front();
        checks++;
        if (act_ok !== cur.exp) begin
          errors++;
          $display("FAIL %s cycle %0d act_ok actual %b expected %b", cur.tag, cyc - 1, act_ok, cur.exp);
        end
        checks++;
        if (off_ok !== '1) begin
          errors++;
          $display("FAIL R8 cycle %0d disabled act_ok actual %b expected %b", cyc - 1, off_ok, {NR{1'b1}});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    act_i = '0;
    ref_i = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (act_ok !== '1) begin
      errors++;
      $display("FAIL R1 in reset act_ok actual %b expected %b", act_ok, {NR{1'b1}});
    end
    rst_n = 1'b1;
    step('0, '0, "R1");
    step('0, '0, "R1");
    // R2 R3 R7: four activates to rank 0, then watch the window expire
    for (int i = 0; i < 5; i++) step(4'b0001, '0, "R3");
    for (int i = 0; i < 12; i++) step('0, '0, "R2");
    // R4: refreshes and activates share the rank 1 budget
    step('0, 4'b0010, "R4");
    step('0, 4'b0010, "R4");
    step(4'b0010, '0, "R4");
    step(4'b0010, '0, "R4");
    step(4'b0010, 4'b0010, "R4");
    for (int i = 0; i < 10; i++) step('0, '0, "R4");
    // R5: coincident activate and refresh on rank 2 make one record each
    for (int i = 0; i < 5; i++) step(4'b0100, 4'b0100, "R5");
    for (int i = 0; i < 10; i++) step('0, '0, "R5");
    // R6 R7: rank 3 strobed whenever allowed, refilling freed slots at once
    for (int i = 0; i < 30; i++) step(4'b1000, '0, "R6");
    for (int i = 0; i < 10; i++) step('0, '0, "R6");
    // R3: pseudo-random mix on all ranks
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[3:0], lfsr[7:4] & lfsr[11:8], "R3");
    end
    for (int i = 0; i < 12; i++) step('0, '0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule